// File: doc/BRIEF.md
# Bank-Interleaved Burst Read Scheduler

This block models the memory side of a read path built from several independent banks that share one byte-wide data bus. A requester hands it read commands over a valid/ready channel, each naming a bank, a row and a starting column. The addressed bank opens the whole row into its sense buffer, which takes a programmable activation time. It then streams one byte per cycle onto the shared bus as a burst of one full row. Afterwards it spends a programmable recovery time writing the row back before it can take another command.

Because each bank keeps its own phase state, a command to bank B+1 can be activating while bank B bursts and bank B-1 recovers. A stream of commands to distinct banks therefore keeps the bus busy every cycle. Bursts leave in the order their commands were accepted. Every byte carries the bank index, and the last byte of each burst is flagged. The cell contents are a fixed arithmetic pattern so that any read can be predicted without a write path.

Top module: `bisched_top`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1 for every value of req_bank.
- R2: A command is accepted on a rising edge where req_valid and req_ready are both 1. From the next cycle, req_ready is 0 whenever req_bank names that bank, until the bank's recovery ends. With default parameters and an idle bus, two commands to one bank are accepted 16 cycles apart.
- R3: The cell at bank b, row r, column c holds the low 8 bits of 37*b + 8*r + c.
- R4: A burst is 8 bytes from the addressed row. It starts at the requested column and steps the column up by one each byte, wrapping from 7 to 0.
- R5: With the bus idle, the first byte of a burst is on the bus T_ACT+2 cycles after the acceptance cycle, which is 4 cycles with defaults.
- R6: rsp_bank equals the bank of the command the byte belongs to. rsp_last is 1 on the 8th byte of each burst and 0 on the others.
- R7: Bursts appear on the bus in the order their commands were accepted, and every accepted command yields exactly one burst.
- R8: When commands to 8 distinct banks are accepted on consecutive cycles, rsp_valid stays 1 for 64 consecutive cycles.
- R9: After the cycle carrying a bank's last byte, req_ready for that bank stays 0 for T_REC cycles (4 by default) and is 1 in the next cycle.
- R10: A command to a bank that is busy does not stop a command to an idle bank from being accepted: req_ready for an idle bank is 1 while another bank is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read command present |
| req_ready | output | 1 | Addressed bank is idle and the command can be taken |
| req_bank | input | 3 | Bank index of the command |
| req_row | input | 3 | Row to open in that bank |
| req_col | input | 3 | Column of the first byte of the burst |
| rsp_valid | output | 1 | A burst byte is on the bus this cycle |
| rsp_data | output | 8 | Burst byte |
| rsp_bank | output | 3 | Bank that produced the byte |
| rsp_last | output | 1 | Final byte of the current burst |

## Verification
The bench reads every cell of every bank at every starting column. A design with a wrong column wrap or a stale sense buffer would return bytes out of place. It issues eight distinct-bank commands back to back, where a scheduler that inserts a gap between bursts would drop rsp_valid for at least one cycle. It repeats commands to one bank, where a short recovery would reopen the bank early and a long one would delay the second acceptance past the predicted cycle. It also issues banks in a scrambled order, where a scheduler that picks bursts by bank readiness rather than arrival would deliver tags out of order.

// File: rtl/bisched_pkg.sv
// Shared types and the behavioural cell pattern for the burst read scheduler.
// Assumes the pattern is only ever read; there is no write path.
package bisched_pkg;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_ACT,
        BK_READY,
        BK_BURST,
        BK_REC
    } bank_state_t;

    // Contents of one storage cell; callers truncate to the data width.
    function automatic int cell_value(input int bank, input int row,
                                      input int col, input int ncol);
        return (bank * 37 + row * ncol + col) % 256;
    endfunction

endpackage

// File: rtl/bisched_bank.sv
// One bank: holds a row/column command, waits out activation, loads the
// opened row into its sense buffer, streams it out from the chosen column
// with wrap-around, then recovers. NCOL must be a power of two.
module bisched_bank #(
    parameter int BANK_ID = 0,
    parameter int NROW    = 8,
    parameter int NCOL    = 8,
    parameter int T_ACT   = 2,
    parameter int T_REC   = 4,
    parameter int DW      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [$clog2(NROW)-1:0]   row,
    input  logic [$clog2(NCOL)-1:0]   col,
    input  logic                      burst_go,
    output logic                      idle,
    output logic                      ready,
    output logic [DW-1:0]             rd_byte
);
    import bisched_pkg::*;

    localparam int RBW  = $clog2(NROW);
    localparam int CBW  = $clog2(NCOL);
    localparam int MX1  = (T_ACT > T_REC) ? T_ACT : T_REC;
    localparam int MAXV = (MX1 > NCOL) ? MX1 : NCOL;
    localparam int CW   = $clog2(MAXV + 1);

    bank_state_t            state;
    logic [CW-1:0]          cnt;
    logic [RBW-1:0]         row_q;
    logic [CBW-1:0]         col_q;
    logic [CBW-1:0]         ptr;
    logic [NCOL-1:0][DW-1:0] sense;

    // Phase sequencer: activation, wait for bus, burst, recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            cnt   <= '0;
            row_q <= '0;
            col_q <= '0;
            ptr   <= '0;
            sense <= '0;
        end else begin
            case (state)
                BK_IDLE: begin
                    if (start) begin
                        state <= BK_ACT;
                        cnt   <= CW'(T_ACT - 1);
                        row_q <= row;
                        col_q <= col;
                    end
                end
                BK_ACT: begin
                    if (cnt == '0) begin
                        state <= BK_READY;
                        for (int j = 0; j < NCOL; j++) begin
                            sense[j] <= DW'(cell_value(BANK_ID, int'(row_q), j, NCOL));
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BK_READY: begin
                    if (burst_go) begin
                        state <= BK_BURST;
                        cnt   <= CW'(NCOL - 1);
                        ptr   <= col_q;
                    end
                end
                BK_BURST: begin
                    ptr <= ptr + 1'b1;
                    if (cnt == '0) begin
                        state <= BK_REC;
                        cnt   <= CW'(T_REC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BK_REC: begin
                    if (cnt == '0) begin
                        state <= BK_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= BK_IDLE;
            endcase
        end
    end

    // Status and the byte selected by the column pointer.
    always_comb begin
        idle    = (state == BK_IDLE);
        ready   = (state == BK_READY);
        rd_byte = sense[ptr];
    end

endmodule

// File: rtl/bisched_order_fifo.sv
// Keeps the bank indices of accepted commands in arrival order so bursts
// leave in that order. DEPTH must be a power of two.
module bisched_order_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                din,
    input  logic                        pop,
    output logic [W-1:0]                dout,
    output logic                        empty,
    output logic [$clog2(DEPTH+1)-1:0]  occ
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Write side storage.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Head of queue.
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (occ == '0);
    end

endmodule

// File: rtl/bisched_bus_seq.sv
// Shared bus sequencer: starts the oldest bank's burst once that bank has
// its row open, and chains the next burst right after the last byte so the
// bus carries no idle cycle while work is queued.
module bisched_bus_seq #(
    parameter int NBANK = 8,
    parameter int NCOL  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       head_valid,
    input  logic [$clog2(NBANK)-1:0]   head_bank,
    input  logic [NBANK-1:0]           bank_ready,
    output logic                       pop,
    output logic [NBANK-1:0]           go,
    output logic                       active,
    output logic [$clog2(NBANK)-1:0]   cur_bank,
    output logic                       last
);
    localparam int BW = $clog2(NBANK);
    localparam int CBW = $clog2(NCOL);

    logic [CBW-1:0] beat;
    logic           take;

    // Decide whether the head burst starts on this edge.
    always_comb begin
        last = active && (beat == CBW'(NCOL - 1));
        take = head_valid && bank_ready[head_bank] && (!active || last);
        pop  = take;
        go   = '0;
        if (take) go[head_bank] = 1'b1;
    end

    // Beat counter and current bank of the burst on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat     <= '0;
            cur_bank <= '0;
        end else if (take) begin
            active   <= 1'b1;
            beat     <= '0;
            cur_bank <= head_bank;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      beat   <= beat + 1'b1;
        end
    end

endmodule

// File: rtl/bisched_top.sv
// Bank-interleaved burst read scheduler. Accepts one command per cycle to
// any idle bank, runs all banks' phases in parallel and puts their bursts
// on one byte-wide bus in acceptance order.
module bisched_top #(
    parameter int NBANK = 8,
    parameter int NROW  = 8,
    parameter int NCOL  = 8,
    parameter int T_ACT = 2,
    parameter int T_REC = 4,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [$clog2(NBANK)-1:0]   req_bank,
    input  logic [$clog2(NROW)-1:0]    req_row,
    input  logic [$clog2(NCOL)-1:0]    req_col,
    output logic                       rsp_valid,
    output logic [DW-1:0]              rsp_data,
    output logic [$clog2(NBANK)-1:0]   rsp_bank,
    output logic                       rsp_last
);
    localparam int BW = $clog2(NBANK);

    logic [NBANK-1:0]          bank_idle;
    logic [NBANK-1:0]          bank_ready;
    logic [NBANK-1:0]          bank_start;
    logic [NBANK-1:0]          bank_go;
    logic [NBANK-1:0][DW-1:0]  bank_byte;
    logic                      accept;
    logic                      head_valid;
    logic                      fifo_empty;
    logic                      fifo_pop;
    logic [BW-1:0]             head_bank;
    logic [BW:0]               fifo_occ;
    logic                      seq_active;
    logic [BW-1:0]             seq_bank;
    logic                      seq_last;

    // Acceptance: addressed bank idle and room in the order queue.
    always_comb begin
        req_ready = bank_idle[req_bank] && (fifo_occ != (BW+1)'(NBANK));
        accept    = req_valid && req_ready;
        head_valid = !fifo_empty;
    end

    genvar gb;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_bank
            assign bank_start[gb] = accept && (req_bank == BW'(gb));

            bisched_bank #(
                .BANK_ID (gb),
                .NROW    (NROW),
                .NCOL    (NCOL),
                .T_ACT   (T_ACT),
                .T_REC   (T_REC),
                .DW      (DW)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (bank_start[gb]),
                .row      (req_row),
                .col      (req_col),
                .burst_go (bank_go[gb]),
                .idle     (bank_idle[gb]),
                .ready    (bank_ready[gb]),
                .rd_byte  (bank_byte[gb])
            );
        end
    endgenerate

    bisched_order_fifo #(
        .DEPTH (NBANK),
        .W     (BW)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (req_bank),
        .pop   (fifo_pop),
        .dout  (head_bank),
        .empty (fifo_empty),
        .occ   (fifo_occ)
    );

    bisched_bus_seq #(
        .NBANK (NBANK),
        .NCOL  (NCOL)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_bank  (head_bank),
        .bank_ready (bank_ready),
        .pop        (fifo_pop),
        .go         (bank_go),
        .active     (seq_active),
        .cur_bank   (seq_bank),
        .last       (seq_last)
    );

    // Bus outputs taken from the bank currently bursting.
    always_comb begin
        rsp_valid = seq_active;
        rsp_bank  = seq_bank;
        rsp_last  = seq_last;
        rsp_data  = bank_byte[seq_bank];
    end

endmodule

// File: rtl/bisched_chk.sv
// Protocol checker for the burst read scheduler, bound to the top module.
// Assumes reset is held low for at least one clock at start.
module bisched_chk #(
    parameter int NBANK = 8,
    parameter int BW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_ready,
    input  logic [BW-1:0] req_bank,
    input  logic          rsp_valid,
    input  logic [BW-1:0] rsp_bank,
    input  logic          rsp_last,
    input  logic [BW:0]   occ
);

    // R2
    ready_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !(req_ready && (req_bank == $past(req_bank))));

    // R6
    burst_tag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> (rsp_valid && (rsp_bank == $past(rsp_bank))));

    // R9
    recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> !(rsp_valid && (rsp_bank == $past(rsp_bank))));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (BW+1)'(NBANK));

endmodule

bind bisched_top bisched_chk #(
    .NBANK (NBANK),
    .BW    (BW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .rsp_valid (rsp_valid),
    .rsp_bank  (rsp_bank),
    .rsp_last  (rsp_last),
    .occ       (fifo_occ)
);

// File: tb/sim_bisched_top.sv
// Self-checking bench: exhaustive cell sweep plus timing, ordering and
// saturation scenarios for the default configuration.
module sim_bisched_top;

    localparam int T_ACT = 2;
    localparam int T_REC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_bank = '0;
    logic [2:0] req_row = '0;
    logic [2:0] req_col = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic [2:0] rsp_bank;
    logic       rsp_last;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int acc = 0;

    logic [7:0] exp_d[$];
    logic [2:0] exp_b[$];
    bit         exp_l[$];

    bisched_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_bank  (rsp_bank),
        .rsp_last  (rsp_last)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Drive a command until accepted; queue the bytes it must return.
    task automatic send(input int b, input int r, input int c);
        req_valid = 1'b1;
        req_bank  = 3'(b);
        req_row   = 3'(r);
        req_col   = 3'(c);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc;
        for (int i = 0; i < 8; i++) begin
            exp_d.push_back(8'((37 * b + 8 * r + ((c + i) % 8)) % 256));
            exp_b.push_back(3'(b));
            exp_l.push_back(i == 7);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_d.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // Bus monitor: every byte matches the next expected one (R3 R4 R6 R7).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_d.size() == 0) begin
                check(1'b0, "R7 unexpected byte", int'(rsp_data), -1);
            end else begin
                logic [7:0] ed;
                logic [2:0] eb;
                bit         el;
                ed = exp_d.pop_front();
                eb = exp_b.pop_front();
                el = exp_l.pop_front();
                check(rsp_data == ed, "R3 R4 data", int'(rsp_data), int'(ed));
                check(rsp_bank == eb, "R6 R7 bank tag", int'(rsp_bank), int'(eb));
                check(rsp_last == el, "R6 last flag", int'(rsp_last), int'(el));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R7 watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int a0;
        int first_cyc;
        int last_cyc;
        int zeros;
        int nvalid;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, ready for every bank, bus idle.
        for (int b = 0; b < 8; b++) begin
            req_bank = 3'(b);
            #1;
            check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        end
        check(rsp_valid == 1'b0, "R1 bus idle after reset", int'(rsp_valid), 0);
        @(negedge clk);

        // R5 / R2 / R9: single command latency and bank holdoff.
        send(3, 5, 6);
        req_bank = 3'd3;
        #1;
        check(req_ready == 1'b0, "R2 ready low after accept", int'(req_ready), 0);
        while (!rsp_valid) @(negedge clk);
        first_cyc = cyc;
        check(first_cyc == acc + T_ACT + 2, "R5 first byte latency", first_cyc - acc, T_ACT + 2);
        while (!rsp_last) @(negedge clk);
        last_cyc = cyc;
        zeros = 0;
        for (int k = 0; k < T_REC; k++) begin
            @(negedge clk);
            #1;
            if (!req_ready) zeros++;
        end
        check(zeros == T_REC, "R9 ready low during recovery", zeros, T_REC);
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R9 ready back after recovery", int'(req_ready), 1);
        check(cyc == last_cyc + T_REC + 1, "R9 ready return cycle", cyc - last_cyc, T_REC + 1);
        drain();

        // R2: same bank twice, acceptance spacing on an idle bus.
        send(5, 1, 2);
        a0 = acc;
        send(5, 2, 3);
        check(acc - a0 == T_ACT + 2 + 8 + T_REC, "R2 same-bank spacing", acc - a0, T_ACT + 2 + 8 + T_REC);
        drain();

        // R10: busy bank does not block an idle one.
        send(1, 0, 0);
        req_valid = 1'b1;
        req_bank  = 3'd1;
        #1;
        check(req_ready == 1'b0, "R10 busy bank not ready", int'(req_ready), 0);
        req_bank = 3'd2;
        #1;
        check(req_ready == 1'b1, "R10 idle bank ready", int'(req_ready), 1);
        req_valid = 1'b0;
        send(2, 4, 4);
        drain();

        // R7: scrambled bank order.
        send(5, 7, 1);
        send(2, 3, 7);
        send(7, 0, 5);
        send(0, 6, 2);
        drain();
        check(exp_d.size() == 0, "R7 all bursts delivered", exp_d.size(), 0);

        // R8: eight distinct banks back to back saturate the bus.
        nvalid = 0;
        fork
            begin
                for (int b = 0; b < 8; b++) send(b, 7 - b, b);
            end
            begin
                while (!rsp_valid) @(negedge clk);
                for (int i = 0; i < 64; i++) begin
                    if (rsp_valid) nvalid++;
                    @(negedge clk);
                end
            end
        join
        check(nvalid == 64, "R8 bus saturated", nvalid, 64);
        drain();

        // R3 R4 R6: exhaustive sweep of every cell and start column.
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                for (int b = 0; b < 8; b++) begin
                    send(b, r, c);
                end
            end
        end
        drain();
        check(exp_d.size() == 0, "R7 sweep fully delivered", exp_d.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule